// File: doc/BRIEF.md
# Timed-Signal Gate Evaluator

This block evaluates one logic gate per operation on timed signal words. A signal word carries a logic level and the time at which that level becomes valid. The block combines the levels with the chosen gate function. The result time is the latest input time plus the fixed delay of that gate, so a chain of operations tracks worst-case settling time through a netlist.

An operation is a 3-bit gate code and up to three 16-bit operands, offered with a valid/ready handshake. Each accepted operation gives exactly one registered result on the next cycle. The result carries a saturation flag and an illegal-code flag. The result stays on the outputs until the consumer takes it.

The control is a two-state machine:
- `ST_EMPTY`: no result is held.
- `ST_FULL`: a result is held.

Its transitions are:
- `T_LOAD`: EMPTY to FULL, when an operation is accepted.
- `T_REFILL`: FULL to FULL, when the result is consumed and a new operation is accepted in the same cycle.
- `T_STALL`: FULL to FULL, when the result is not consumed.
- `T_DRAIN`: FULL to EMPTY, when the result is consumed and no operation arrives.
- `T_IDLE`: EMPTY to EMPTY, when nothing is offered.

Top module: `tsig_gate_eval`

## Requirements
- R1: Word format. Bit 15 is the level (1 = high) and bits 14..0 are the valid time. Gate code 0 (complement) inverts bit 15 of operand a and keeps its time unchanged, with no delay added.
- R2: Gate code 1 (AND) gives the AND of the levels of a and b. The result time is the larger of their two times, with no delay added.
- R3: Gate code 2 (OR) gives the OR of the levels of a and b. The result time is the larger of their two times, with no delay added.
- R4: Gate code 3 (two-input NAND) gives the inverted AND of the levels of a and b. The result time is the larger of their two times plus 9.
- R5: Gate code 4 (three-input OR) gives the OR of the levels of a, b and c. The result time is the largest of the three times plus 30.
- R6: Gate code 5 (two-input XOR) gives the XOR of the levels of a and b. The result time is the larger of their two times plus 35.
- R7: If adding the delay gives a time above 0x7FFF, the time field becomes 0x7FFF and the overflow flag is set. A sum equal to 0x7FFF does not set the flag. The level bit is never changed by the addition.
- R8: Gate codes 6 and 7 return operand a unchanged, set the illegal flag and clear the overflow flag.
- R9: The input is ready whenever no result is held or the consumer is ready. The result of an operation accepted at one clock edge is valid after that edge. A held result that is consumed with no new operation leaves the output not valid.
- R10: While a result is valid and not consumed, the result word and both flags stay stable and the input is not ready.
- R11: While reset is asserted and after its release, out_valid is low and in_ready is high.
- R12: Chained use: XOR of (low @0, low @10) gives low @45. NAND of that result with (high @10) gives high @54. Three-input OR of (high @54, low @0, low @10) gives high @84.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| gate_code | input | 3 | Gate selection (0..5 legal) |
| opnd_a | input | 16 | Operand a |
| opnd_b | input | 16 | Operand b |
| opnd_c | input | 16 | Operand c (three-input OR only) |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 16 | Result level and time |
| out_ovf | output | 1 | Time saturated |
| out_illegal | output | 1 | Gate code was 6 or 7 |

## Verification
The assertions watch the handshake on every cycle:
- a result appears after each acceptance;
- a stalled result stays frozen;
- the input is ready when no result is held;
- the output empties after a drain;
- reset holds the output not valid.

They also check, on every valid result, that the overflow flag comes only with an all-ones time field and never together with the illegal flag. The level and time for each gate code can only be shown by the bench scenarios. These compare random and boundary operands against a separately computed model. The same holds for the exact saturation threshold, the illegal-code pass-through and the chained 45/84 example.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

    parameter int WORD_W = 16;
    localparam int TIME_W = WORD_W - 1;
    localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

    typedef struct packed {
        logic              lvl;
        logic [TIME_W-1:0] t;
    } tsig_t;

    typedef enum logic [2:0] {
        GC_NOT   = 3'd0,
        GC_AND   = 3'd1,
        GC_OR    = 3'd2,
        GC_NAND2 = 3'd3,
        GC_OR3   = 3'd4,
        GC_XOR2  = 3'd5
    } gate_code_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;

    // level complement, time untouched
    function automatic tsig_t sig_inv(tsig_t x);
        tsig_t r;
        r.lvl = ~x.lvl;
        r.t   = x.t;
        return r;
    endfunction

    // worst-case AND: both levels ANDed, latest time wins
    function automatic tsig_t sig_and(tsig_t x, tsig_t y);
        tsig_t r;
        r.lvl = x.lvl & y.lvl;
        r.t   = (x.t > y.t) ? x.t : y.t;
        return r;
    endfunction

    // OR built by De Morgan over the timed AND
    function automatic tsig_t sig_or(tsig_t x, tsig_t y);
        return sig_inv(sig_and(sig_inv(x), sig_inv(y)));
    endfunction

endpackage

// File: rtl/tsig_delay_add.sv
module tsig_delay_add
    import tsig_pkg::*;
#(
    parameter int DELAY = 0
) (
    input  tsig_t sig_in,
    output tsig_t sig_out,
    output logic  sat
);
    localparam int SUM_W = TIME_W + 1;

    generate
        if (DELAY == 0) begin : g_pass
            assign sig_out = sig_in;
            assign sat     = 1'b0;
        end else begin : g_add
            logic [SUM_W-1:0] sum;
            assign sum         = {1'b0, sig_in.t} + SUM_W'(DELAY);
            assign sat         = sum[SUM_W-1];
            assign sig_out.lvl = sig_in.lvl;
            assign sig_out.t   = sum[SUM_W-1] ? TIME_MAX : sum[TIME_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/tsig_gate_core.sv
module tsig_gate_core
    import tsig_pkg::*;
#(
    parameter int NAND_DELAY = 9,
    parameter int OR3_DELAY  = 30,
    parameter int XOR_DELAY  = 35
) (
    input  logic [2:0] code,
    input  tsig_t      a,
    input  tsig_t      b,
    input  tsig_t      c,
    output tsig_t      res,
    output logic       ovf,
    output logic       illegal
);
    tsig_t raw_not, raw_and, raw_or, raw_nand, raw_or3, raw_xor;
    tsig_t dly_nand, dly_or3, dly_xor;
    logic  sat_nand, sat_or3, sat_xor;

    always_comb begin
        raw_not  = sig_inv(a);
        raw_and  = sig_and(a, b);
        raw_or   = sig_or(a, b);
        raw_nand = sig_inv(raw_and);
        raw_or3  = sig_or(raw_or, c);
        raw_xor  = sig_or(sig_and(a, sig_inv(b)), sig_and(sig_inv(a), b));
    end

    tsig_delay_add #(.DELAY(NAND_DELAY)) u_dly_nand (
        .sig_in(raw_nand), .sig_out(dly_nand), .sat(sat_nand));
    tsig_delay_add #(.DELAY(OR3_DELAY)) u_dly_or3 (
        .sig_in(raw_or3), .sig_out(dly_or3), .sat(sat_or3));
    tsig_delay_add #(.DELAY(XOR_DELAY)) u_dly_xor (
        .sig_in(raw_xor), .sig_out(dly_xor), .sat(sat_xor));

    always_comb begin
        res     = a;
        ovf     = 1'b0;
        illegal = 1'b0;
        case (code)
            GC_NOT:   res = raw_not;
            GC_AND:   res = raw_and;
            GC_OR:    res = raw_or;
            GC_NAND2: begin res = dly_nand; ovf = sat_nand; end
            GC_OR3:   begin res = dly_or3;  ovf = sat_or3;  end
            GC_XOR2:  begin res = dly_xor;  ovf = sat_xor;  end
            default:  illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/tsig_gate_eval.sv
module tsig_gate_eval
    import tsig_pkg::*;
#(
    parameter int NAND_DELAY = 9,
    parameter int OR3_DELAY  = 30,
    parameter int XOR_DELAY  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        gate_code,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [WORD_W-1:0] opnd_c,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              out_ovf,
    output logic              out_illegal
);
    hold_state_e state_q, state_d;
    tsig_t       core_res, res_q;
    logic        core_ovf, core_ill, ovf_q, ill_q;
    logic        accept;

    tsig_gate_core #(
        .NAND_DELAY(NAND_DELAY),
        .OR3_DELAY (OR3_DELAY),
        .XOR_DELAY (XOR_DELAY)
    ) u_core (
        .code   (gate_code),
        .a      (tsig_t'(opnd_a)),
        .b      (tsig_t'(opnd_b)),
        .c      (tsig_t'(opnd_c)),
        .res    (core_res),
        .ovf    (core_ovf),
        .illegal(core_ill)
    );

    assign accept = in_valid && in_ready;

    // next-state: T_LOAD, T_REFILL, T_STALL, T_DRAIN, T_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // outputs: handshake decode and result holding register
    always_comb begin
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        out_valid = (state_q == ST_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            ovf_q <= 1'b0;
            ill_q <= 1'b0;
        end else if (accept) begin
            res_q <= core_res;
            ovf_q <= core_ovf;
            ill_q <= core_ill;
        end
    end

    assign out_word    = res_q;
    assign out_ovf     = ovf_q;
    assign out_illegal = ill_q;

endmodule

// File: rtl/tsig_gate_eval_chk.sv
module tsig_gate_eval_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_word,
    input logic        out_ovf,
    input logic        out_illegal
);
    assert_sat_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_word[14:0] == 15'h7FFF));

    assert_ill_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_ovf && out_illegal));

    assert_accept_yields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_empty_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_word) && $stable(out_ovf) && $stable(out_illegal)));

    assert_stall_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_reset_empty_R11: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind tsig_gate_eval tsig_gate_eval_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_word   (out_word),
    .out_ovf    (out_ovf),
    .out_illegal(out_illegal)
);

// File: tb/tsig_gate_eval_tb_top.sv
`timescale 1ns/1ps
module tsig_gate_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  gate_code = 3'd0;
    logic [15:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_word;
    logic        out_ovf;
    logic        out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tsig_gate_eval dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .gate_code(gate_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_ovf(out_ovf), .out_illegal(out_illegal)
    );

    // reference: returns {ovf, illegal, word}
    function automatic logic [17:0] ref_eval(input logic [2:0] op,
                                             input logic [15:0] a, b, c);
        int ta, tb, tc, t, d;
        logic lvl;
        ta = int'(a[14:0]); tb = int'(b[14:0]); tc = int'(c[14:0]);
        d = 0;
        case (op)
            3'd0: begin lvl = ~a[15]; t = ta; end
            3'd1: begin lvl = a[15] & b[15]; t = (ta > tb) ? ta : tb; end
            3'd2: begin lvl = a[15] | b[15]; t = (ta > tb) ? ta : tb; end
            3'd3: begin lvl = ~(a[15] & b[15]); t = (ta > tb) ? ta : tb; d = 9; end
            3'd4: begin
                lvl = a[15] | b[15] | c[15];
                t = (ta > tb) ? ta : tb;
                if (tc > t) t = tc;
                d = 30;
            end
            3'd5: begin lvl = a[15] ^ b[15]; t = (ta > tb) ? ta : tb; d = 35; end
            default: return {1'b0, 1'b1, a};
        endcase
        t = t + d;
        if (t > 32767) return {1'b1, 1'b0, lvl, 15'h7FFF};
        return {1'b0, 1'b0, lvl, t[14:0]};
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_result(input string tag, input logic [17:0] exp);
        checks++;
        if ({out_ovf, out_illegal, out_word} !== exp || out_valid !== 1'b1) begin
            fails++;
            $display("FAIL %s actual=ovf%0b ill%0b %h valid%0b expected=ovf%0b ill%0b %h",
                     tag, out_ovf, out_illegal, out_word, out_valid,
                     exp[17], exp[16], exp[15:0]);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [15:0] a, b, c,
                          input string tag);
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1;
        gate_code = op; opnd_a = a; opnd_b = b; opnd_c = c;
        @(negedge clk);
        in_valid = 1'b0;
        check_result(tag, ref_eval(op, a, b, c));
    endtask

    function automatic logic [14:0] pick_time();
        case ($urandom % 8)
            0: return 15'h0000;
            1: return 15'h7FFF;
            2: return 15'(32767 - ($urandom % 40));
            default: return 15'($urandom);
        endcase
    endfunction

    function automatic logic [15:0] pick_sig();
        return {1'($urandom), pick_time()};
    endfunction

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        // R11: reset state
        check_bit("R11 out_valid in reset", out_valid, 1'b0);
        check_bit("R11 in_ready in reset", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R11 out_valid after reset", out_valid, 1'b0);
        check_bit("R11 in_ready after reset", in_ready, 1'b1);

        // R12: chained example
        run_op(3'd5, 16'h0000, 16'h000A, 16'h0000, "R12 xor low@45");
        check_bit("R12 xor word", out_word == 16'h002D, 1'b1);
        run_op(3'd3, 16'h002D, 16'h800A, 16'h0000, "R12 nand high@54");
        check_bit("R12 nand word", out_word == 16'h8036, 1'b1);
        run_op(3'd4, 16'h8036, 16'h0000, 16'h000A, "R12 or3 high@84");
        check_bit("R12 or3 word", out_word == 16'h8054, 1'b1);

        // R1: complement at time max, no delay
        run_op(3'd0, 16'h7FFF, 16'h1234, 16'h0, "R1 not at max time");
        check_bit("R1 not word", out_word == 16'hFFFF, 1'b1);
        // R7: saturation threshold
        run_op(3'd3, 16'h7FF6, 16'h0001, 16'h0, "R7 nand exact max");
        check_bit("R7 no ovf at exact max", out_ovf, 1'b0);
        run_op(3'd3, 16'h7FF7, 16'h0001, 16'h0, "R7 nand saturate");
        check_bit("R7 ovf set", out_ovf, 1'b1);
        run_op(3'd5, 16'hFFFF, 16'h0000, 16'h0, "R7 xor saturate keeps level");
        check_bit("R7 level kept", out_word[15], 1'b1);
        run_op(3'd4, 16'h0000, 16'h0000, 16'h7FE2, "R7 or3 c-time saturate");
        // R8: illegal codes
        run_op(3'd6, 16'hABCD, 16'h1111, 16'h2222, "R8 code6 passthrough");
        run_op(3'd7, 16'h7FFF, 16'h1111, 16'h2222, "R8 code7 passthrough");
        // R2/R3 ignore c
        run_op(3'd1, 16'h8005, 16'h8009, 16'hFFFF, "R2 and ignores c");
        run_op(3'd2, 16'h0005, 16'h0003, 16'hFFFF, "R3 or ignores c");

        // R9/R10: backpressure
        @(negedge clk); out_ready = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check_bit("R9 drained after consume", out_valid, 1'b0);
        in_valid = 1'b1; out_ready = 1'b0;
        gate_code = 3'd1; opnd_a = 16'h8010; opnd_b = 16'h8020; opnd_c = '0;
        @(negedge clk);
        check_result("R9 result after accept", ref_eval(3'd1, 16'h8010, 16'h8020, 16'h0));
        gate_code = 3'd5; opnd_a = 16'h8100; opnd_b = 16'h0050;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_result("R10 held during stall", ref_eval(3'd1, 16'h8010, 16'h8020, 16'h0));
            check_bit("R10 in_ready low during stall", in_ready, 1'b0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_result("R9 refill result", ref_eval(3'd5, 16'h8100, 16'h0050, 16'h0));
        @(negedge clk);
        check_bit("R9 one result per op", out_valid, 1'b0);

        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            op = 3'($urandom % 8);
            run_op(op, pick_sig(), pick_sig(), pick_sig(), req_of(op));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule